// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Splitter and Cycle Decoder

This block sits between an 8-bit processor whose low address byte shares its pins with the data byte and a plain memory and I/O system. While the processor's address strobe is high, the block passes the shared lines through as the low address byte. When the strobe falls, it keeps that byte. The upper address byte arrives on its own dedicated lines and is joined on unchanged, giving a full 16-bit address.

The active-low read and write lines, together with the memory/I/O select, are decoded into a six-wide one-hot cycle vector. The vector marks memory read, memory write, I/O read, I/O write, no access, or the forbidden case in which read and write are both asserted.

A ready input stretches any real transfer. While ready is low the block reports a wait state and withholds the completion flag. A data-direction output tells the board buffers to drive toward the processor only during a read. A forbidden cycle sets an error bit that stays set until reset.

Top module: `adbus_demux`

## Requirements
- R1: After a synchronous active-low reset, with the strobe low, `err_flag` is 0 and `addr_out[7:0]` is 0x00.
- R2: While `addr_strobe` is 1, `addr_out[7:0]` equals `ad_lo` in the same cycle, following every change.
- R3: Once `addr_strobe` has been 0 at a rising clock edge, `addr_out[7:0]` keeps the value that `ad_lo` had at the last rising edge where the strobe was 1. It ignores `ad_lo` until the strobe rises again.
- R4: `addr_out[15:8]` always equals `addr_hi_in`, combinationally.
- R5: `kind_oh` bit positions are: bit0 memory read, bit1 memory write, bit2 I/O read, bit3 I/O write, bit4 no access, bit5 forbidden. With `io_sel`=0, `wr_n`=1 and `rd_n`=0, bit0 is set. With `io_sel`=0, `wr_n`=0 and `rd_n`=1, bit1 is set. With `io_sel`=1, `wr_n`=1 and `rd_n`=0, bit2 is set. With `io_sel`=1, `wr_n`=0 and `rd_n`=1, bit3 is set.
- R6: With `rd_n`=0 and `wr_n`=0, only bit5 is set, whatever `io_sel` is. With `rd_n`=1 and `wr_n`=1, only bit4 is set. Exactly one bit of `kind_oh` is set at all times.
- R7: During any of the four transfers, `cyc_wait` equals the inverse of `ready` and `cyc_done` equals `ready`. The two are never 1 together.
- R8: `drive_cpu` is 1 exactly when a memory read or an I/O read is decoded, and is 0 otherwise.
- R9: `err_flag` becomes 1 at the first rising edge at which read and write are both low. It is not 1 before that edge, and it stays 1 until reset.
- R10: In the no-access and forbidden cases, `cyc_wait` and `cyc_done` are both 0 whatever `ready` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ad_lo | input | 8 | Shared low address/data lines from the processor |
| addr_hi_in | input | 8 | Dedicated upper address lines |
| addr_strobe | input | 1 | Address-valid strobe, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| io_sel | input | 1 | 0 = memory access, 1 = I/O access |
| ready | input | 1 | Target ready; low stretches a transfer |
| addr_out | output | 16 | Demultiplexed 16-bit address |
| kind_oh | output | 6 | One-hot cycle kind (bit map in R5) |
| cyc_wait | output | 1 | Transfer held in wait state |
| cyc_done | output | 1 | Transfer completes this cycle |
| drive_cpu | output | 1 | Data buffers point toward the processor |
| err_flag | output | 1 | Sticky forbidden-cycle error |

## Verification
The captured low byte is the only data state in the block. A wrong capture or hold shows on `addr_out[7:0]` within one cycle of the strobe falling, and it stays visible for every following cycle until the next strobe. The decode and handshake paths are combinational, so a wrong bit in `kind_oh`, `cyc_wait`, `cyc_done` or `drive_cpu` appears in the same cycle as the offending control code. The error bit lags its cause by exactly one edge, so a wrong set or a lost set is visible at the first sample after that edge.

// File: rtl/adbus_pkg.sv
// Package: shared cycle-kind encoding for the bus splitter.
// Assumes the one-hot output bit index equals the enum value.
package adbus_pkg;

    localparam int KIND_N = 6;

    typedef enum logic [2:0] {
        CK_MEM_RD = 3'd0,
        CK_MEM_WR = 3'd1,
        CK_IO_RD  = 3'd2,
        CK_IO_WR  = 3'd3,
        CK_IDLE   = 3'd4,
        CK_BAD    = 3'd5
    } cyc_kind_e;

endpackage

// File: rtl/adbus_lo_latch.sv
// Low address capture: transparent while the strobe is high, holds afterwards.
// Assumes the strobe is synchronous to clk and that the shared lines settle
// while it is high.
module adbus_lo_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] lo_addr
);

    logic [W-1:0] held_q;

    // Keep the last byte seen while the strobe was high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (strobe)
            held_q <= bus_in;
    end

    // Pass the bus straight through during the strobe, else the held byte.
    always_comb begin
        lo_addr = strobe ? bus_in : held_q;
    end

endmodule

// File: rtl/adbus_ctl_decode.sv
// Control decoder: maps select, write and read lines to a cycle kind.
// Assumes active-low read/write strobes; both low is forbidden.
module adbus_ctl_decode
    import adbus_pkg::*;
(
    input  logic      io_sel,
    input  logic      wr_n,
    input  logic      rd_n,
    output cyc_kind_e kind
);

    // Classify the current control code.
    always_comb begin
        unique case ({wr_n, rd_n})
            2'b00:   kind = CK_BAD;
            2'b11:   kind = CK_IDLE;
            2'b10:   kind = io_sel ? CK_IO_RD : CK_MEM_RD;
            default: kind = io_sel ? CK_IO_WR : CK_MEM_WR;
        endcase
    end

endmodule

// File: rtl/adbus_wait_ctl.sv
// Transfer control: wait/complete handshake, buffer direction, sticky error.
// Assumes kind is stable for the whole access.
module adbus_wait_ctl
    import adbus_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cyc_kind_e kind,
    input  logic      ready,
    output logic      cyc_wait,
    output logic      cyc_done,
    output logic      drive_cpu,
    output logic      err_flag
);

    logic is_xfer;
    logic is_read;
    logic err_q;

    // Identify real transfers and the reads among them.
    always_comb begin
        is_xfer   = (kind == CK_MEM_RD) || (kind == CK_MEM_WR) ||
                    (kind == CK_IO_RD)  || (kind == CK_IO_WR);
        is_read   = (kind == CK_MEM_RD) || (kind == CK_IO_RD);
        cyc_wait  = is_xfer && !ready;
        cyc_done  = is_xfer && ready;
        drive_cpu = is_read;
    end

    // Latch any forbidden cycle until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (kind == CK_BAD)
            err_q <= 1'b1;
    end

    assign err_flag = err_q;

endmodule

// File: rtl/adbus_demux.sv
// Top: splits the time-shared bus into a 16-bit address and decodes cycles.
// Assumes one processor master; upper address lines are never shared.
module adbus_demux
    import adbus_pkg::*;
#(
    parameter int LO_W = 8,
    parameter int HI_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LO_W-1:0]        ad_lo,
    input  logic [HI_W-1:0]        addr_hi_in,
    input  logic                   addr_strobe,
    input  logic                   rd_n,
    input  logic                   wr_n,
    input  logic                   io_sel,
    input  logic                   ready,
    output logic [LO_W+HI_W-1:0]   addr_out,
    output logic [KIND_N-1:0]      kind_oh,
    output logic                   cyc_wait,
    output logic                   cyc_done,
    output logic                   drive_cpu,
    output logic                   err_flag
);

    localparam int ADDR_W = LO_W + HI_W;

    logic [LO_W-1:0] lo_addr;
    cyc_kind_e       kind;

    adbus_lo_latch #(.W(LO_W)) u_lo (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (addr_strobe),
        .bus_in  (ad_lo),
        .lo_addr (lo_addr)
    );

    adbus_ctl_decode u_dec (
        .io_sel (io_sel),
        .wr_n   (wr_n),
        .rd_n   (rd_n),
        .kind   (kind)
    );

    adbus_wait_ctl u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .ready     (ready),
        .cyc_wait  (cyc_wait),
        .cyc_done  (cyc_done),
        .drive_cpu (drive_cpu),
        .err_flag  (err_flag)
    );

    // Join the upper lines with the captured low byte.
    always_comb begin
        addr_out = ADDR_W'({addr_hi_in, lo_addr});
    end

    // Expand the cycle kind into one strobe per kind.
    for (genvar k = 0; k < KIND_N; k++) begin : g_oh
        assign kind_oh[k] = (kind == cyc_kind_e'(3'(k)));
    end

endmodule

// File: rtl/adbus_demux_chk.sv
// Checker: temporal properties of the bus splitter, bound to the top.
module adbus_demux_chk
    import adbus_pkg::*;
#(
    parameter int LO_W = 8,
    parameter int HI_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 addr_strobe,
    input logic                 rd_n,
    input logic                 wr_n,
    input logic [LO_W+HI_W-1:0] addr_out,
    input logic [KIND_N-1:0]    kind_oh,
    input logic                 cyc_wait,
    input logic                 cyc_done,
    input logic                 drive_cpu,
    input logic                 err_flag
);

    // R3: low byte frozen while the strobe stays low
    a_r3_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_strobe && $past(!addr_strobe) && $past(rst_n))
            |-> $stable(addr_out[LO_W-1:0]));

    // R6: exactly one cycle kind at a time
    a_r6_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(kind_oh) == 1);

    // R7: wait and completion never together
    a_r7_wait_excl: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_wait |-> !cyc_done);

    // R8: buffers turn toward the processor only on a read code
    a_r8_dir_read: assert property (@(posedge clk) disable iff (!rst_n)
        drive_cpu |-> (!rd_n && wr_n));

    // R9: a forbidden code sets the error at the next edge
    a_r9_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !wr_n) |=> err_flag);

    // R9: the error stays set until reset
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R10: no handshake outside a transfer
    a_r10_no_hs: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_oh[4] || kind_oh[5]) |-> (!cyc_wait && !cyc_done));

endmodule

bind adbus_demux adbus_demux_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_strobe (addr_strobe),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .addr_out    (addr_out),
    .kind_oh     (kind_oh),
    .cyc_wait    (cyc_wait),
    .cyc_done    (cyc_done),
    .drive_cpu   (drive_cpu),
    .err_flag    (err_flag)
);

// File: tb/test_adbus_demux.sv
module test_adbus_demux;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ad_lo = '0;
    logic [7:0]  addr_hi_in = '0;
    logic        addr_strobe = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        io_sel = 1'b0;
    logic        ready = 1'b1;
    logic [15:0] addr_out;
    logic [5:0]  kind_oh;
    logic        cyc_wait, cyc_done, drive_cpu, err_flag;

    int errs = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    adbus_demux i_adbus_demux (
        .clk(clk), .rst_n(rst_n), .ad_lo(ad_lo), .addr_hi_in(addr_hi_in),
        .addr_strobe(addr_strobe), .rd_n(rd_n), .wr_n(wr_n), .io_sel(io_sel),
        .ready(ready), .addr_out(addr_out), .kind_oh(kind_oh),
        .cyc_wait(cyc_wait), .cyc_done(cyc_done), .drive_cpu(drive_cpu),
        .err_flag(err_flag)
    );

    // Vector: {io_sel, wr_n, rd_n, ready, kind[5:0], wait, done, dir}
    localparam logic [12:0] VEC [16] = '{
        13'b0000_100000_000, 13'b0001_100000_000,
        13'b0010_000010_100, 13'b0011_000010_010,
        13'b0100_000001_101, 13'b0101_000001_011,
        13'b0110_010000_000, 13'b0111_010000_000,
        13'b1000_100000_000, 13'b1001_100000_000,
        13'b1010_001000_100, 13'b1011_001000_010,
        13'b1100_000100_101, 13'b1101_000100_011,
        13'b1110_010000_000, 13'b1111_010000_000
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; addr_strobe = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1 low addr", 16'(addr_out[7:0]), 16'h00);
        chk("R1 err", 16'(err_flag), 16'h0);

        // Table walk over every control code and ready value.
        for (int i = 0; i < 16; i++) begin
            string kreq, hreq;
            @(negedge clk);
            {io_sel, wr_n, rd_n, ready} = VEC[i][12:9];
            #1;
            kreq = (VEC[i][8] || VEC[i][7]) ? "R6 kind" : "R5 kind";
            hreq = (VEC[i][8] || VEC[i][7]) ? "R10 handshake" : "R7 handshake";
            chk(kreq, 16'(kind_oh), 16'(VEC[i][8:3]));
            chk(hreq, 16'({cyc_wait, cyc_done}), 16'(VEC[i][2:1]));
            chk("R8 direction", 16'(drive_cpu), 16'(VEC[i][0]));
        end

        // Stretched memory read: three wait cycles then completion.
        @(negedge clk);
        io_sel = 1'b0; wr_n = 1'b1; rd_n = 1'b0; ready = 1'b0;
        for (int c = 0; c < 3; c++) begin
            #1;
            chk("R7 wait held", 16'({cyc_wait, cyc_done}), 16'b10);
            @(negedge clk);
        end
        ready = 1'b1;
        #1;
        chk("R7 completes", 16'({cyc_wait, cyc_done}), 16'b01);
        @(negedge clk);
        rd_n = 1'b1;

        // Address capture, transparency, hold, pass-through.
        @(negedge clk);
        addr_hi_in = 8'hA5; ad_lo = 8'h34; addr_strobe = 1'b1;
        #1;
        chk("R2 transparent", addr_out, 16'hA534);
        ad_lo = 8'h56;
        #1;
        chk("R2 follows", addr_out, 16'hA556);
        @(negedge clk);
        addr_strobe = 1'b0; ad_lo = 8'h99;
        #1;
        chk("R3 hold", addr_out, 16'hA556);
        addr_hi_in = 8'h3C;
        #1;
        chk("R4 upper pass", addr_out, 16'h3C56);
        repeat (3) begin
            @(negedge clk);
            ad_lo = ad_lo + 8'h11;
        end
        #1;
        chk("R3 ignores bus", addr_out, 16'h3C56);
        @(negedge clk);
        ad_lo = 8'h77; addr_strobe = 1'b1;
        #1;
        chk("R2 new strobe", addr_out, 16'h3C77);
        @(negedge clk);
        addr_strobe = 1'b0; ad_lo = 8'h00;
        #1;
        chk("R3 new hold", addr_out, 16'h3C77);

        // Sticky error: set one edge after a forbidden code, kept, cleared.
        do_reset();
        chk("R1 err after reset", 16'(err_flag), 16'h0);
        @(negedge clk);
        rd_n = 1'b0; wr_n = 1'b0; io_sel = 1'b1;
        #1;
        chk("R9 not before edge", 16'(err_flag), 16'h0);
        @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1;
        #1;
        chk("R9 set", 16'(err_flag), 16'h1);
        repeat (4) @(negedge clk);
        #1;
        chk("R9 sticky", 16'(err_flag), 16'h1);
        do_reset();
        chk("R9 cleared by reset", 16'(err_flag), 16'h0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule